// File: doc/BRIEF.md
# Synchronous-Rectifier Dead-Time Meter

This block times the gaps between a synchronous-rectifier gate drive and the comparator that watches the rectified voltage in a switching power stage. Each sense channel measures two intervals in clock cycles. The leading gap runs from the gate turning off to the comparator going high. The trailing gap runs from the comparator going low to the gate turning back on. Both asynchronous inputs pass through a two-flop synchronizer, and all edges are found on the synchronized copies.

Each gap has a raw count, which holds the last completed measurement, and an exponentially filtered average. The comparator high time is also measured, and it is stored in one of two registers depending on whether the switching cycle is even or odd. When edges arrive in the wrong order, a sticky status flag is set and the broken measurement is thrown away. A shared clear strobe resets the flags.

Two channels are built from one channel module by a generate loop. The channels share nothing except the clock, the reset and the clear strobe.

Top module: `sr_deadtime_meter`

## Requirements
- R1: After reset every count, average and flag output is zero, and an input edge takes effect only once it has passed a two-flop synchronizer.
- R2: The lead raw count is loaded with the number of clock cycles from a gate falling edge to the next comparator rising edge, provided the gate is low when the comparator rises.
- R3: The trail raw count is loaded with the number of clock cycles from a comparator falling edge to the next gate rising edge, provided the comparator is low when the gate rises.
- R4: Every measurement saturates at 2^CNT_W-1 instead of wrapping.
- R5: Each average starts at zero and is updated only when its raw count loads, as avg + ((raw - avg) >>> AVG_SHIFT), using the newly loaded raw value and an arithmetic (floor) shift.
- R6: A comparator rising edge while the gate is high sets the lead error flag, and it leaves the lead raw count and lead average unchanged.
- R7: A gate rising edge while the comparator is high sets the trail error flag, and it leaves the trail raw count and trail average unchanged.
- R8: Error flags stay set until clr_err_i is high at a clock edge, which clears the flags of every channel. If a new error and a clear fall on the same edge, the flag stays set.
- R9: Each completed comparator high-time measurement (rising edge to falling edge) goes to the even register and the odd register in turn, starting with even after reset. An order error does not stop this measurement.
- R10: The channels are independent. Activity on one channel never changes another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_i | input | N_CH | Rectifier gate drive per channel, asynchronous |
| comp_i | input | N_CH | Rectified-voltage comparator per channel, asynchronous |
| clr_err_i | input | 1 | Synchronous clear strobe for all error flags |
| lead_raw_o | output | N_CH x CNT_W | Last gate-off to comparator-high interval |
| lead_avg_o | output | N_CH x CNT_W | Filtered lead interval |
| trail_raw_o | output | N_CH x CNT_W | Last comparator-low to gate-on interval |
| trail_avg_o | output | N_CH x CNT_W | Filtered trail interval |
| hi_even_o | output | N_CH x CNT_W | Comparator high time, even cycles |
| hi_odd_o | output | N_CH x CNT_W | Comparator high time, odd cycles |
| lead_err_o | output | N_CH | Sticky lead-order error |
| trail_err_o | output | N_CH | Sticky trail-order error |

## Verification
The assertions assume three things: only one edge of each input lands per synchronized sample, a gate edge and a comparator edge of the same channel never reach the synchronizer on the same edge, and clr_err_i is a clean synchronous pulse. The stimulus meets these assumptions by changing inputs only on the falling clock edge and by keeping every gap between edges at one cycle or more. Random gaps, high times and on-times are combined with directed cases: minimum gaps of one cycle, saturation, both kinds of order error, and a clear that lands on the same edge as a new error.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/dtm_sync.sv
module dtm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dtm_edge_det.sv
module dtm_edge_det
  import dtm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  d_i,
  output edge_t e_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  assign e_o.lvl  = d_i;
  assign e_o.rise = d_i & ~prev_q;
  assign e_o.fall = ~d_i & prev_q;
endmodule

// File: rtl/dtm_interval.sv
// Armed interval timer: start restarts the count, stop closes it unless aborted.
module dtm_interval #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         abort_i,
  output logic         load_o,
  output logic [W-1:0] meas_o,
  output logic [W-1:0] raw_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic         armed_q;
  logic [W-1:0] cnt_q;

  assign load_o = stop_i & armed_q & ~abort_i;
  assign meas_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      raw_o   <= '0;
    end else begin
      if (load_o) raw_o <= cnt_q;
      if (stop_i) armed_q <= 1'b0;
      else if (armed_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (start_i) begin
        armed_q <= 1'b1;
        cnt_q   <= W'(1);
      end
    end
  end
endmodule

// File: rtl/dtm_ewma.sv
module dtm_ewma #(
  parameter int W     = 16,
  parameter int SHIFT = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] meas_i,
  output logic [W-1:0] avg_o
);
  logic signed [W:0] diff;
  logic [W-1:0]      step;

  assign diff = $signed({1'b0, meas_i}) - $signed({1'b0, avg_o});
  // result stays within [min(avg,meas), max(avg,meas)], so modular add is exact
  assign step = W'(diff >>> SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     avg_o <= '0;
    else if (load_i) avg_o <= avg_o + step;
  end
endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
  import dtm_pkg::*;
#(
  parameter int W           = 16,
  parameter int AVG_SHIFT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gate_i,
  input  logic         comp_i,
  input  logic         clr_err_i,
  output logic [W-1:0] lead_raw_o,
  output logic [W-1:0] lead_avg_o,
  output logic [W-1:0] trail_raw_o,
  output logic [W-1:0] trail_avg_o,
  output logic [W-1:0] hi_even_o,
  output logic [W-1:0] hi_odd_o,
  output logic         lead_err_o,
  output logic         trail_err_o
);
  logic  gate_s, comp_s;
  edge_t g_e, c_e;

  dtm_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_i), .q_o(gate_s));
  dtm_sync #(.STAGES(SYNC_STAGES)) u_sync_comp (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(comp_i), .q_o(comp_s));

  dtm_edge_det u_edge_gate (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_s), .e_o(g_e));
  dtm_edge_det u_edge_comp (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(comp_s), .e_o(c_e));

  logic         lead_bad, trail_bad;
  logic         lead_ld, trail_ld, hi_ld;
  logic [W-1:0] lead_meas, trail_meas, hi_meas, hi_raw;

  assign lead_bad  = c_e.rise & g_e.lvl;
  assign trail_bad = g_e.rise & c_e.lvl;

  dtm_interval #(.W(W)) u_lead (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(g_e.fall), .stop_i(c_e.rise), .abort_i(g_e.lvl),
    .load_o(lead_ld), .meas_o(lead_meas), .raw_o(lead_raw_o));

  dtm_interval #(.W(W)) u_trail (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(c_e.fall), .stop_i(g_e.rise), .abort_i(c_e.lvl),
    .load_o(trail_ld), .meas_o(trail_meas), .raw_o(trail_raw_o));

  dtm_interval #(.W(W)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(c_e.rise), .stop_i(c_e.fall), .abort_i(1'b0),
    .load_o(hi_ld), .meas_o(hi_meas), .raw_o(hi_raw));

  dtm_ewma #(.W(W), .SHIFT(AVG_SHIFT)) u_lead_avg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(lead_ld), .meas_i(lead_meas),
    .avg_o(lead_avg_o));

  dtm_ewma #(.W(W), .SHIFT(AVG_SHIFT)) u_trail_avg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(trail_ld), .meas_i(trail_meas),
    .avg_o(trail_avg_o));

  logic odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q     <= 1'b0;
      hi_even_o <= '0;
      hi_odd_o  <= '0;
    end else if (hi_ld) begin
      odd_q <= ~odd_q;
      if (odd_q) hi_odd_o  <= hi_meas;
      else       hi_even_o <= hi_meas;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_err_o  <= 1'b0;
      trail_err_o <= 1'b0;
    end else begin
      if (lead_bad)       lead_err_o <= 1'b1;
      else if (clr_err_i) lead_err_o <= 1'b0;
      if (trail_bad)      trail_err_o <= 1'b1;
      else if (clr_err_i) trail_err_o <= 1'b0;
    end
  end

  logic unused_hi;
  assign unused_hi = ^hi_raw;
endmodule

// File: rtl/sr_deadtime_meter.sv
module sr_deadtime_meter #(
  parameter int N_CH        = 2,
  parameter int CNT_W       = 16,
  parameter int AVG_SHIFT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CH-1:0]            gate_i,
  input  logic [N_CH-1:0]            comp_i,
  input  logic                       clr_err_i,
  output logic [N_CH-1:0][CNT_W-1:0] lead_raw_o,
  output logic [N_CH-1:0][CNT_W-1:0] lead_avg_o,
  output logic [N_CH-1:0][CNT_W-1:0] trail_raw_o,
  output logic [N_CH-1:0][CNT_W-1:0] trail_avg_o,
  output logic [N_CH-1:0][CNT_W-1:0] hi_even_o,
  output logic [N_CH-1:0][CNT_W-1:0] hi_odd_o,
  output logic [N_CH-1:0]            lead_err_o,
  output logic [N_CH-1:0]            trail_err_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dtm_channel #(
      .W(CNT_W), .AVG_SHIFT(AVG_SHIFT), .SYNC_STAGES(SYNC_STAGES)
    ) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .gate_i     (gate_i[c]),
      .comp_i     (comp_i[c]),
      .clr_err_i  (clr_err_i),
      .lead_raw_o (lead_raw_o[c]),
      .lead_avg_o (lead_avg_o[c]),
      .trail_raw_o(trail_raw_o[c]),
      .trail_avg_o(trail_avg_o[c]),
      .hi_even_o  (hi_even_o[c]),
      .hi_odd_o   (hi_odd_o[c]),
      .lead_err_o (lead_err_o[c]),
      .trail_err_o(trail_err_o[c])
    );
  end
endmodule

// File: rtl/sr_deadtime_meter_chk.sv
module sr_deadtime_meter_chk #(
  parameter int N_CH  = 2,
  parameter int CNT_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       clr_err_i,
  input logic [N_CH-1:0][CNT_W-1:0] lead_raw_o,
  input logic [N_CH-1:0][CNT_W-1:0] lead_avg_o,
  input logic [N_CH-1:0][CNT_W-1:0] trail_raw_o,
  input logic [N_CH-1:0][CNT_W-1:0] trail_avg_o,
  input logic [N_CH-1:0][CNT_W-1:0] hi_even_o,
  input logic [N_CH-1:0][CNT_W-1:0] hi_odd_o,
  input logic [N_CH-1:0]            lead_err_o,
  input logic [N_CH-1:0]            trail_err_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    a_r8_lead_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(lead_err_o[c]) && !$past(clr_err_i)) |-> lead_err_o[c]);
    a_r8_trail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(trail_err_o[c]) && !$past(clr_err_i)) |-> trail_err_o[c]);
    a_r6_lead_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lead_err_o[c]) |-> ($stable(lead_raw_o[c]) && $stable(lead_avg_o[c])));
    a_r7_trail_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(trail_err_o[c]) |-> ($stable(trail_raw_o[c]) && $stable(trail_avg_o[c])));
    a_r5_lead_avg_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lead_avg_o[c] > $past(lead_avg_o[c])) |-> (lead_avg_o[c] <= lead_raw_o[c]));
    a_r5_lead_avg_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lead_avg_o[c] < $past(lead_avg_o[c])) |-> (lead_avg_o[c] >= lead_raw_o[c]));
    a_r5_trail_avg_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trail_avg_o[c] > $past(trail_avg_o[c])) |-> (trail_avg_o[c] <= trail_raw_o[c]));
    a_r2_lead_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(lead_raw_o[c]) |-> (lead_raw_o[c] != '0));
    a_r3_trail_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(trail_raw_o[c]) |-> (trail_raw_o[c] != '0));
    a_r9_one_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(!$stable(hi_even_o[c]) && !$stable(hi_odd_o[c])));
  end
endmodule

bind sr_deadtime_meter sr_deadtime_meter_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_err_i(clr_err_i),
  .lead_raw_o(lead_raw_o), .lead_avg_o(lead_avg_o),
  .trail_raw_o(trail_raw_o), .trail_avg_o(trail_avg_o),
  .hi_even_o(hi_even_o), .hi_odd_o(hi_odd_o),
  .lead_err_o(lead_err_o), .trail_err_o(trail_err_o));

// File: tb/sr_deadtime_meter_bench.sv
module sr_deadtime_meter_bench;
  localparam int N_CH = 2;
  localparam int W    = 10;
  localparam int MAXV = (1 << W) - 1;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic [N_CH-1:0]        gate_i = '1;
  logic [N_CH-1:0]        comp_i = '0;
  logic                   clr_err_i = 1'b0;
  logic [N_CH-1:0][W-1:0] lead_raw_o, lead_avg_o, trail_raw_o, trail_avg_o;
  logic [N_CH-1:0][W-1:0] hi_even_o, hi_odd_o;
  logic [N_CH-1:0]        lead_err_o, trail_err_o;

  sr_deadtime_meter #(.N_CH(N_CH), .CNT_W(W)) u_sr_deadtime_meter (.*);

  always #5 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;
  int e_lraw[N_CH], e_lavg[N_CH], e_traw[N_CH], e_tavg[N_CH];
  int e_ev[N_CH], e_od[N_CH], e_par[N_CH];
  bit e_lerr[N_CH], e_terr[N_CH];

  function automatic int clip(int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  function automatic int avg_next(int a, int r);
    int d;
    d = r - a;
    return a + (d >>> 3);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic hi_model(int ch, int h);
    if (e_par[ch] == 0) e_ev[ch] = clip(h);
    else                e_od[ch] = clip(h);
    e_par[ch] ^= 1;
  endtask

  task automatic check_ch(int ch, string tag);
    chk($sformatf("R2 ch%0d lead raw %s", ch, tag), int'(lead_raw_o[ch]), e_lraw[ch]);
    chk($sformatf("R5 ch%0d lead avg %s", ch, tag), int'(lead_avg_o[ch]), e_lavg[ch]);
    chk($sformatf("R3 ch%0d trail raw %s", ch, tag), int'(trail_raw_o[ch]), e_traw[ch]);
    chk($sformatf("R5 ch%0d trail avg %s", ch, tag), int'(trail_avg_o[ch]), e_tavg[ch]);
    chk($sformatf("R9 ch%0d hi even %s", ch, tag), int'(hi_even_o[ch]), e_ev[ch]);
    chk($sformatf("R9 ch%0d hi odd %s", ch, tag), int'(hi_odd_o[ch]), e_od[ch]);
    chk($sformatf("R6 ch%0d lead err %s", ch, tag), int'(lead_err_o[ch]), int'(e_lerr[ch]));
    chk($sformatf("R7 ch%0d trail err %s", ch, tag), int'(trail_err_o[ch]), int'(e_terr[ch]));
  endtask

  // expects gate high, comp low on entry
  task automatic sw_cycle(int ch, int ld, int hi, int tr, int on);
    gate_i[ch] = 1'b0; wait_n(ld);
    comp_i[ch] = 1'b1; wait_n(hi);
    comp_i[ch] = 1'b0; wait_n(tr);
    gate_i[ch] = 1'b1; wait_n(on);
    e_lraw[ch] = clip(ld); e_lavg[ch] = avg_next(e_lavg[ch], e_lraw[ch]);
    e_traw[ch] = clip(tr); e_tavg[ch] = avg_next(e_tavg[ch], e_traw[ch]);
    hi_model(ch, hi);
  endtask

  task automatic lead_fault(int ch, int a, int b);
    comp_i[ch] = 1'b1; wait_n(a);
    comp_i[ch] = 1'b0; wait_n(b);
    e_lerr[ch] = 1'b1;
    hi_model(ch, a);
  endtask

  task automatic trail_fault(int ch, int ld, int x, int y, int z);
    gate_i[ch] = 1'b0; wait_n(ld);
    comp_i[ch] = 1'b1; wait_n(x);
    gate_i[ch] = 1'b1; wait_n(y);
    comp_i[ch] = 1'b0; wait_n(z);
    e_lraw[ch] = clip(ld); e_lavg[ch] = avg_next(e_lavg[ch], e_lraw[ch]);
    e_terr[ch] = 1'b1;
    hi_model(ch, x + y);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < N_CH; c++) begin
      e_lraw[c] = 0; e_lavg[c] = 0; e_traw[c] = 0; e_tavg[c] = 0;
      e_ev[c] = 0; e_od[c] = 0; e_par[c] = 0; e_lerr[c] = 0; e_terr[c] = 0;
    end
    wait_n(5);
    rst_ni = 1'b1;
    wait_n(6);
    for (int c = 0; c < N_CH; c++) check_ch(c, "R1 reset");

    // directed
    sw_cycle(0, 5, 12, 7, 10);  check_ch(0, "basic");
    check_ch(1, "R10 idle ch1");
    sw_cycle(0, 1, 1, 1, 8);    check_ch(0, "minimum gaps");
    sw_cycle(1, 20, 30, 3, 8);  check_ch(1, "basic");
    sw_cycle(1, 1100, 4, 1030, 8); check_ch(1, "R4 saturation");
    sw_cycle(1, 2, 1200, 2, 8); check_ch(1, "R4 hi saturation");

    // order errors
    lead_fault(0, 4, 8);        check_ch(0, "R6 lead fault");
    sw_cycle(0, 6, 9, 5, 8);    check_ch(0, "R6 recovery");
    trail_fault(1, 7, 5, 4, 8); check_ch(1, "R7 trail fault");
    sw_cycle(1, 9, 6, 11, 8);   check_ch(1, "R7 recovery");

    // clear
    clr_err_i = 1'b1; wait_n(1); clr_err_i = 1'b0; wait_n(1);
    for (int c = 0; c < N_CH; c++) begin
      e_lerr[c] = 0; e_terr[c] = 0;
      check_ch(c, "R8 clear");
    end

    // clear on the same edge as a new lead fault: set wins
    comp_i[0] = 1'b1; wait_n(2);
    clr_err_i = 1'b1; wait_n(1); clr_err_i = 1'b0;
    wait_n(3); comp_i[0] = 1'b0; wait_n(8);
    e_lerr[0] = 1'b1; hi_model(0, 6);
    check_ch(0, "R8 set wins");
    check_ch(1, "R8 set wins other");

    // concurrent channels
    fork
      sw_cycle(0, 13, 22, 4, 12);
      sw_cycle(1, 3, 17, 19, 9);
    join
    check_ch(0, "R10 concurrent");
    check_ch(1, "R10 concurrent");

    // constrained random
    for (int i = 0; i < 60; i++) begin
      int ch, ld, hi, tr, on;
      ch = int'($urandom_range(N_CH - 1, 0));
      ld = int'($urandom_range(40, 1));
      hi = int'($urandom_range(30, 1));
      tr = int'($urandom_range(40, 1));
      on = int'($urandom_range(20, 6));
      sw_cycle(ch, ld, hi, tr, on);
      check_ch(ch, "random");
    end

    finish_run();
  end
endmodule